// File: doc/BRIEF.md
# Latched Protection Fault Manager

This block takes the protection event flags of a single-phase buck converter and decides what the power stage does with them. Each event has its own qualifying conditions. Supply lockout only holds the gates off while it lasts. Over-temperature, absolute over-voltage, windowed over-voltage and sustained current limiting each latch the converter off. For each latched fault the block selects a gate state for the driver logic and records the cause that tripped first.

The analog comparators sit outside the block and deliver synchronous, glitch-free flags to it. A latched fault is cleared only when enable is dropped or the supply-OK flag falls, which stands for a power recycle. While the converter is latched off, the block asks the soft-start capacitor to discharge, so the converter restarts from a clean ramp once the fault is cleared.

Top module: `prot_fault_mgr`

## Requirements
- R1: While `supply_ok_i` is 0, `gate_mode_o` is 1 (both gates off) in the same cycle. Lockout is not latched: once `supply_ok_i` and `en_i` are both 1 again with no fault pending, `gate_mode_o` is 0 (switching) and `latched_o` is 0.
- R2: While `en_i` is 0, `gate_mode_o` is 1. Sampling `en_i`=0 or `supply_ok_i`=0 at a clock edge clears `latched_o` to 0, clears `cause_o` to 0 and clears the current-limit pulse count.
- R3: When `ss_done_i` and `core_low_i` are both 1, each cycle with `clim_pulse_i`=1 adds one qualified pulse. The 32nd consecutive qualified pulse sets `latched_o` at the next edge, with `cause_o`=4 and `gate_mode_o`=2 (high side off, low side on).
- R4: The pulse count returns to zero when `sw_tick_i` ends a switching cycle in which no `clim_pulse_i` was seen, including in the tick cycle itself. It also returns to zero in any cycle where `core_low_i` is 0.
- R5: While `ss_done_i` is 0, current-limit pulses are not counted and cannot latch the converter.
- R6: `core_high_i` latches with `cause_o`=3 and `gate_mode_o`=2 only when `ss_done_i` is 1 and `xition_i` is 0. It has no effect during soft-start or during a transition.
- R7: `core_abs_ov_i` latches with `cause_o`=2 and `gate_mode_o`=2 at the next edge, regardless of soft-start or transition state.
- R8: `over_temp_i` latches with `cause_o`=1 and `gate_mode_o`=1 at the next edge.
- R9: If several faults arrive in the same cycle, the cause is chosen in this order: over-temperature, absolute over-voltage, window over-voltage, current limit. Once latched, `cause_o` does not change until cleared, and later faults are ignored.
- R10: `ss_dischg_o` is 1 exactly while `latched_o` is 1.
- R11: After reset, `latched_o`, `ss_dischg_o` and `cause_o` are 0. With no fault pending, `gate_mode_o` is 0 when both enable and supply-OK are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable; low clears latched faults |
| supply_ok_i | input | 1 | Supplies above lockout threshold |
| ss_done_i | input | 1 | Soft-start ramp complete |
| xition_i | input | 1 | Output-voltage or sleep transition in progress |
| clim_pulse_i | input | 1 | One-cycle strobe per current-limit event |
| core_low_i | input | 1 | Core below regulation window |
| core_high_i | input | 1 | Core above regulation window |
| core_abs_ov_i | input | 1 | Core above the absolute over-voltage limit |
| over_temp_i | input | 1 | Die over-temperature |
| sw_tick_i | input | 1 | One-cycle strobe at the end of each switching cycle |
| gate_mode_o | output | 2 | 0 switching, 1 both gates off, 2 low side held on |
| latched_o | output | 1 | Converter latched off |
| ss_dischg_o | output | 1 | Request soft-start capacitor discharge |
| cause_o | output | 3 | First latched cause: 0 none, 1 thermal, 2 absolute OV, 3 window OV, 4 current limit |

## Verification
The bench looks for off-by-one errors in the pulse count. It runs exactly 31 qualified pulses and then the 32nd. It also runs streaks broken by an idle switching cycle or by the core returning into the window. A counter that trips early, or one that fails to reset, latches at the wrong cycle. Window over-voltage is applied during soft-start and during transitions, where a design that ignores the qualifier would latch. Absolute over-voltage is applied in those same states, where a design that over-qualifies it would fail to latch. Coincident faults and later faults check that the recorded cause neither takes the wrong priority nor gets overwritten. A power recycle checks that the supply-OK path clears the latch, not only the enable path.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [1:0] {
    GATE_RUN     = 2'd0,
    GATE_ALL_OFF = 2'd1,
    GATE_LOW_ON  = 2'd2
  } gate_mode_e;

  typedef enum logic [2:0] {
    CAUSE_NONE   = 3'd0,
    CAUSE_OT     = 3'd1,
    CAUSE_ABS_OV = 3'd2,
    CAUSE_WIN_OV = 3'd3,
    CAUSE_CLIM   = 3'd4
  } cause_e;
endpackage

// File: rtl/prot_clim_counter.sv
module prot_clim_counter #(
  parameter int LIMIT = 32,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic arm_i,
  input  logic pulse_i,
  input  logic tick_i,
  output logic trip_o
);
  logic [CW-1:0] cnt_q;
  logic          seen_q;
  logic          qual;

  assign qual   = arm_i && pulse_i;
  assign trip_o = qual && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (!arm_i)
        cnt_q <= '0;
      else if (tick_i && !seen_q && !pulse_i)
        cnt_q <= '0;
      else if (qual)
        cnt_q <= cnt_q + 1'b1;
      seen_q <= tick_i ? 1'b0 : (seen_q || pulse_i);
    end
  end
endmodule

// File: rtl/prot_fault_arb.sv
module prot_fault_arb
  import prot_pkg::*;
(
  input  logic   ot_i,
  input  logic   abs_i,
  input  logic   win_i,
  input  logic   clim_i,
  output logic   any_o,
  output cause_e cause_o
);
  always_comb begin
    cause_o = CAUSE_NONE;
    if (ot_i)        cause_o = CAUSE_OT;
    else if (abs_i)  cause_o = CAUSE_ABS_OV;
    else if (win_i)  cause_o = CAUSE_WIN_OV;
    else if (clim_i) cause_o = CAUSE_CLIM;
  end
  assign any_o = ot_i || abs_i || win_i || clim_i;
endmodule

// File: rtl/prot_gate_map.sv
module prot_gate_map
  import prot_pkg::*;
(
  input  logic       inactive_i,
  input  logic       latched_i,
  input  cause_e     cause_i,
  output gate_mode_e mode_o
);
  always_comb begin
    if (inactive_i)
      mode_o = GATE_ALL_OFF;
    else if (latched_i)
      mode_o = (cause_i == CAUSE_OT) ? GATE_ALL_OFF : GATE_LOW_ON;
    else
      mode_o = GATE_RUN;
  end
endmodule

// File: rtl/prot_fault_mgr.sv
module prot_fault_mgr
  import prot_pkg::*;
#(
  parameter int CLIM_PULSES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       supply_ok_i,
  input  logic       ss_done_i,
  input  logic       xition_i,
  input  logic       clim_pulse_i,
  input  logic       core_low_i,
  input  logic       core_high_i,
  input  logic       core_abs_ov_i,
  input  logic       over_temp_i,
  input  logic       sw_tick_i,
  output logic [1:0] gate_mode_o,
  output logic       latched_o,
  output logic       ss_dischg_o,
  output logic [2:0] cause_o
);
  logic       inactive;
  logic       latched_q;
  cause_e     cause_q;
  logic       clim_trip;
  logic       win_ov;
  logic       any_fault;
  cause_e     new_cause;
  gate_mode_e mode;

  assign inactive = !en_i || !supply_ok_i;
  assign win_ov   = core_high_i && ss_done_i && !xition_i;

  prot_clim_counter #(.LIMIT(CLIM_PULSES)) u_clim (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (inactive || latched_q),
    .arm_i   (ss_done_i && core_low_i),
    .pulse_i (clim_pulse_i),
    .tick_i  (sw_tick_i),
    .trip_o  (clim_trip)
  );

  prot_fault_arb u_arb (
    .ot_i    (over_temp_i),
    .abs_i   (core_abs_ov_i),
    .win_i   (win_ov),
    .clim_i  (clim_trip),
    .any_o   (any_fault),
    .cause_o (new_cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (inactive) begin
      latched_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
    end else if (!latched_q && any_fault) begin
      latched_q <= 1'b1;
      cause_q   <= new_cause;
    end
  end

  prot_gate_map u_map (
    .inactive_i (inactive),
    .latched_i  (latched_q),
    .cause_i    (cause_q),
    .mode_o     (mode)
  );

  assign gate_mode_o = mode;
  assign latched_o   = latched_q;
  assign ss_dischg_o = latched_q;
  assign cause_o     = cause_q;
endmodule

// File: rtl/prot_fault_mgr_chk.sv
module prot_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       supply_ok_i,
  input logic       ss_done_i,
  input logic       xition_i,
  input logic       clim_pulse_i,
  input logic       core_high_i,
  input logic       core_abs_ov_i,
  input logic       over_temp_i,
  input logic [1:0] gate_mode_o,
  input logic       latched_o,
  input logic       ss_dischg_o,
  input logic [2:0] cause_o
);
  AST_LOCKOUT_GATES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_i |-> gate_mode_o == 2'd1); // R1
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !latched_o && cause_o == 3'd0); // R2
  AST_ABS_OV_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && supply_ok_i && !latched_o && core_abs_ov_i && !over_temp_i
    |=> latched_o && cause_o == 3'd2); // R7
  AST_WIN_IGNORED_SS: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && supply_ok_i && !latched_o && !ss_done_i && !core_abs_ov_i && !over_temp_i
    |=> !latched_o); // R5
  AST_WIN_IGNORED_XITION: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && supply_ok_i && !latched_o && xition_i && core_high_i && !core_abs_ov_i
    && !over_temp_i && !clim_pulse_i |=> !latched_o); // R6
  AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o && cause_o == 3'd1 |-> gate_mode_o == 2'd1); // R8
  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    latched_o && en_i && supply_ok_i |=> latched_o && $stable(cause_o)); // R9
  AST_DISCHG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ss_dischg_o == latched_o); // R10
endmodule

bind prot_fault_mgr prot_fault_mgr_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (en_i),
  .supply_ok_i   (supply_ok_i),
  .ss_done_i     (ss_done_i),
  .xition_i      (xition_i),
  .clim_pulse_i  (clim_pulse_i),
  .core_high_i   (core_high_i),
  .core_abs_ov_i (core_abs_ov_i),
  .over_temp_i   (over_temp_i),
  .gate_mode_o   (gate_mode_o),
  .latched_o     (latched_o),
  .ss_dischg_o   (ss_dischg_o),
  .cause_o       (cause_o)
);

// File: tb/prot_fault_mgr_bench.sv
module prot_fault_mgr_bench;
  localparam int LIMIT = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, ok = 0, ssd = 0, xit = 0, pulse = 0, low = 0, high = 0, absov = 0, ot = 0, tick = 0;
  logic [1:0] gate_mode;
  logic latched, dischg;
  logic [2:0] cause;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R11";

  int m_lat = 0, m_cause = 0, m_cnt = 0, m_seen = 0;

  always #4 clk = ~clk;

  prot_fault_mgr #(.CLIM_PULSES(LIMIT)) u_prot_fault_mgr (
    .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(ok), .ss_done_i(ssd),
    .xition_i(xit), .clim_pulse_i(pulse), .core_low_i(low), .core_high_i(high),
    .core_abs_ov_i(absov), .over_temp_i(ot), .sw_tick_i(tick),
    .gate_mode_o(gate_mode), .latched_o(latched), .ss_dischg_o(dischg), .cause_o(cause)
  );

  function automatic int exp_gate();
    if (!en || !ok) return 1;
    if (m_lat != 0) return (m_cause == 1) ? 1 : 2;
    return 0;
  endfunction

  function automatic int pick_cause(bit clim_trip);
    if (ot) return 1;
    if (absov) return 2;
    if (high && ssd && !xit) return 3;
    if (clim_trip) return 4;
    return 0;
  endfunction

  task automatic model_step();
    bit qual;
    bit trip;
    int c;
    if (!en || !ok) begin
      m_lat = 0; m_cause = 0; m_cnt = 0; m_seen = 0;
    end else if (m_lat != 0) begin
      m_cnt = 0; m_seen = 0;
    end else begin
      qual = pulse && low && ssd;
      trip = qual && (m_cnt == LIMIT - 1);
      c = pick_cause(trip);
      if (c != 0) begin m_lat = 1; m_cause = c; end
      if (!(ssd && low)) m_cnt = 0;
      else if (tick && m_seen == 0 && !pulse) m_cnt = 0;
      else if (qual) m_cnt = m_cnt + 1;
      m_seen = tick ? 0 : ((m_seen != 0 || pulse) ? 1 : 0);
      if (m_lat != 0) begin m_cnt = 0; m_seen = 0; end
    end
  endtask

  task automatic check_now();
    int eg;
    eg = exp_gate();
    vectors++;
    if (gate_mode !== 2'(eg) || latched !== 1'(m_lat) || dischg !== 1'(m_lat) || cause !== 3'(m_cause)) begin
      fails++;
      $display("FAIL %s: gate=%0d lat=%0d dis=%0d cause=%0d expected gate=%0d lat=%0d dis=%0d cause=%0d",
               tag, gate_mode, latched, dischg, cause, eg, m_lat, m_lat, m_cause);
    end
  endtask

  // inputs are set right after a negedge; check, advance model, wait for next negedge
  task automatic cyc();
    #1;
    check_now();
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    pulse = 0; low = 0; high = 0; absov = 0; ot = 0; tick = 0; xit = 0;
  endtask

  task automatic recycle_en();
    en = 0; cyc(); en = 1; cyc();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED_1234);
    @(negedge clk);
    tag = "R11"; #1; check_now();
    @(negedge clk);
    rst_n = 1'b1;
    en = 1; ok = 1; ssd = 1;
    tag = "R11"; cyc(); cyc();

    // R1 lockout, not latched
    tag = "R1"; ok = 0; cyc(); cyc(); ok = 1; cyc(); cyc();

    // R8 over-temperature, R10 discharge, then R2 clear by enable
    tag = "R8"; ot = 1; cyc(); ot = 0; cyc(); cyc();
    tag = "R10"; cyc();
    tag = "R2"; recycle_en(); cyc();

    // R7 absolute OV during soft-start and transition
    tag = "R7"; ssd = 0; xit = 1; absov = 1; cyc(); quiet(); cyc(); cyc();
    tag = "R2"; ok = 0; cyc(); ok = 1; ssd = 1; cyc();

    // R6 window OV qualified
    tag = "R6"; ssd = 0; high = 1; cyc(); cyc();
    ssd = 1; xit = 1; cyc(); cyc();
    xit = 0; cyc(); quiet(); cyc();
    recycle_en();

    // R9 coincident faults and freeze
    tag = "R9"; ot = 1; absov = 1; high = 1; cyc(); quiet(); cyc();
    absov = 1; cyc(); absov = 0; high = 1; cyc(); quiet(); cyc();
    recycle_en();
    absov = 1; high = 1; cyc(); quiet(); ot = 1; cyc(); ot = 0; cyc();
    recycle_en();

    // R3 exactly 31 then the 32nd pulse
    tag = "R3"; low = 1;
    for (int i = 0; i < LIMIT - 1; i++) begin pulse = 1; tick = 1; cyc(); end
    pulse = 0; tick = 0; cyc();
    pulse = 1; tick = 1; cyc(); quiet(); cyc(); cyc();
    recycle_en();

    // R4 idle switching cycle resets count
    tag = "R4"; low = 1;
    for (int i = 0; i < 20; i++) begin pulse = 1; tick = 1; cyc(); end
    pulse = 0; tick = 1; cyc(); tick = 0;
    for (int i = 0; i < LIMIT - 1; i++) begin pulse = 1; cyc(); end
    pulse = 0; cyc();
    pulse = 1; cyc(); pulse = 0; cyc();
    recycle_en();
    // R4 core back in window resets count
    low = 1;
    for (int i = 0; i < 25; i++) begin pulse = 1; cyc(); end
    low = 0; cyc(); low = 1;
    for (int i = 0; i < LIMIT - 1; i++) begin pulse = 1; cyc(); end
    pulse = 0; cyc(); quiet(); recycle_en();

    // R5 pulses during soft-start ignored
    tag = "R5"; ssd = 0; low = 1;
    for (int i = 0; i < 40; i++) begin pulse = 1; cyc(); end
    ssd = 1;
    for (int i = 0; i < LIMIT - 1; i++) begin pulse = 1; cyc(); end
    pulse = 0; cyc(); pulse = 1; cyc(); quiet(); cyc();
    recycle_en();

    // constrained random mix
    tag = "R9";
    for (int i = 0; i < 6000; i++) begin
      en    = ($urandom_range(0, 99) != 0);
      ok    = ($urandom_range(0, 149) != 0);
      ssd   = ($urandom_range(0, 9) != 0);
      xit   = ($urandom_range(0, 5) == 0);
      low   = ($urandom_range(0, 19) != 0);
      pulse = ($urandom_range(0, 9) < 8);
      tick  = ($urandom_range(0, 3) == 0);
      high  = ($urandom_range(0, 299) == 0);
      absov = ($urandom_range(0, 599) == 0);
      ot    = ($urandom_range(0, 599) == 0);
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule